// File: doc/BRIEF.md
# Programmable SCL Timing Generator

This block produces the serial clock for a two-wire bus controller. It divides the system clock by a programmed amount and walks through one bus-clock period made of a low phase and a high phase. Along the way it marks three points with single-cycle strobes: the start of each period, the point in the low phase where the data line may change, and the middle of the high phase where the data line is sampled. A command engine outside this block starts and stops it with an enable, and can freeze it with a stall input. Byte and bit sequencing belong to that engine, not to this block.

The period comes from a 7-bit divider value, T. Each step of the phase counter lasts 2*(1+T) system clocks. A period is ten steps: six low steps, then four high steps, so one period takes 20*(1+T) system clocks. Software writes T through an 8-bit write port. The top bit of the write data is a guard: a write with that bit set is dropped. A new value is held in a shadow register and only takes effect when a period boundary is crossed. If a target holds the bus clock low after this block has released it, the high phase waits until the line reads back high.

The block has no streaming data path, so it has no valid/ready handshake. All pins are plain control and status levels or single-cycle pulses, and nothing at its edge applies back-pressure.

Top module: `scl_timebase`

## Requirements
- R1: While reset is applied and `run_en` is low, `scl_out` is 1 and `drive_tick`, `sample_tick` and `period_tick` are 0.
- R2: With no stall, each period lasts 20*(1+T) clocks. The first 12*(1+T) clocks have `scl_out` at 0 and the remaining 8*(1+T) have it at 1. After reset T is 1, so the period is 40 clocks.
- R3: A write with `prd_wdata[7]` = 1 is ignored, and the period length does not change.
- R4: A write with `prd_wdata[7]` = 0 loads T from `prd_wdata[6:0]`. A field value of 0 is stored as 1.
- R5: A loaded T takes effect from the first period that begins after the clock edge where the write is sampled. This includes a write sampled on the same edge that ends a period: the period that starts on that edge still uses the old T.
- R6: `drive_tick` pulses for one clock at the start of low step 3 (counting from 0), 6*(1+T) clocks into the period, once per period. `scl_out` is 0 at that time.
- R7: `sample_tick` pulses for one clock at the start of high step 8, 16*(1+T) clocks into the period, once per period. `scl_out` and `scl_in` are both 1 at that time.
- R8: `period_tick` pulses for one clock in the first clock of each period. At most one of the three strobes is high in any clock.
- R9: During the high phase, a clock in which `scl_in` reads 0 does not advance the generator. `scl_out` stays 1 and the period grows by one clock for each such clock.
- R10: A clock in which `hold` is 1 does not advance the generator. `scl_out` holds its level, no strobe is issued, and the period grows by one clock.
- R11: While `run_en` is 0, `scl_out` is 1 and the counters are cleared. The first clock after `run_en` returns to 1 (without `hold`) starts a new period with `period_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Generator enable from the command engine |
| hold | input | 1 | Stall from the command engine; freezes all counting |
| scl_in | input | 1 | Bus clock level read back from the line |
| prd_wr | input | 1 | Write strobe for the period register |
| prd_wdata | input | 8 | Bit 7 is the guard (1 = drop the write); bits 6:0 are T |
| scl_out | output | 1 | Bus clock drive: 0 = pull low, 1 = release |
| drive_tick | output | 1 | Strobe: the data line may change now |
| sample_tick | output | 1 | Strobe: sample the data line now |
| period_tick | output | 1 | Strobe: first clock of a bus-clock period |

## Verification
Two things can land in the same clock here. A period-register write can be sampled on the edge where the period wraps, and the shadow load and the active-value reload can collide. The bench finds a period start, counts to the last clock of that period, and writes a new T there. It then checks that the next period still lasts 40 clocks and that the one after it lasts 60. It also compares every output on every clock against a behavioural model. That model holds the written value separately from the value in use, so a reload that took the new value too early shows up as a mismatch on the first differing clock.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic { PH_LOW = 1'b0, PH_HIGH = 1'b1 } scl_phase_e;

  // Width of a counter that must hold values 0..n-1
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/scl_period_reg.sv
module scl_period_reg #(
  parameter int TPR_W     = 7,
  parameter int TPR_RESET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TPR_W:0]   wr_data,
  output logic [TPR_W-1:0] tpr_q
);
  logic             guard;
  logic [TPR_W-1:0] field;
  logic [TPR_W-1:0] clamped;

  assign guard   = wr_data[TPR_W];
  assign field   = wr_data[TPR_W-1:0];
  // zero is outside the legal range; promote to the smallest legal value
  assign clamped = (field == '0) ? TPR_W'(1) : field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tpr_q <= TPR_W'(TPR_RESET);
    else if (wr_en && !guard)   tpr_q <= clamped;
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int TPR_W     = 7,
  parameter int TPR_RESET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             advance,
  input  logic             reload,
  input  logic [TPR_W-1:0] tpr_next,
  output logic             unit_start,
  output logic             unit_end
);
  localparam int PC_W = TPR_W + 1;

  logic [TPR_W-1:0] tpr_act;
  logic [PC_W-1:0]  pcnt;
  logic [PC_W-1:0]  limit;

  // one step lasts 2*(1+T) clocks: count 0 .. 2T+1
  assign limit      = {tpr_act, 1'b1};
  assign unit_start = (pcnt == '0);
  assign unit_end   = (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pcnt <= '0;
    else if (!run_en)      pcnt <= '0;
    else if (advance)      pcnt <= unit_end ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tpr_act <= TPR_W'(TPR_RESET);
    else if (reload)  tpr_act <= tpr_next;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_pkg::*;
#(
  parameter int LOW_UNITS   = 6,
  parameter int HIGH_UNITS  = 4,
  parameter int DRIVE_UNIT  = 3,
  parameter int SAMPLE_UNIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic hold,
  input  logic scl_in,
  input  logic unit_start,
  input  logic unit_end,
  output logic advance,
  output logic period_end,
  output logic scl_out,
  output logic drive_tick,
  output logic sample_tick,
  output logic period_tick
);
  localparam int TOTAL  = LOW_UNITS + HIGH_UNITS;
  localparam int UC_W   = cnt_width(TOTAL);
  localparam logic [UC_W-1:0] LAST_U   = UC_W'(TOTAL - 1);
  localparam logic [UC_W-1:0] HIGH_U   = UC_W'(LOW_UNITS);
  localparam logic [UC_W-1:0] DRIVE_U  = UC_W'(DRIVE_UNIT);
  localparam logic [UC_W-1:0] SAMPLE_U = UC_W'(SAMPLE_UNIT);

  logic [UC_W-1:0] ucnt;
  scl_phase_e      phase;
  logic            stall;
  logic            step_start;

  assign phase      = (ucnt >= HIGH_U) ? PH_HIGH : PH_LOW;
  // a target holding the line low during our high phase stretches it
  assign stall      = hold || (phase == PH_HIGH && !scl_in);
  assign advance    = run_en && !stall;
  assign period_end = unit_end && (ucnt == LAST_U);
  assign step_start = advance && unit_start;

  assign scl_out     = !run_en || (phase == PH_HIGH);
  assign period_tick = step_start && (ucnt == '0);
  assign drive_tick  = step_start && (ucnt == DRIVE_U);
  assign sample_tick = step_start && (ucnt == SAMPLE_U);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ucnt <= '0;
    else if (!run_en)              ucnt <= '0;
    else if (advance && unit_end)  ucnt <= (ucnt == LAST_U) ? '0 : ucnt + 1'b1;
  end
endmodule

// File: rtl/scl_timebase.sv
module scl_timebase #(
  parameter int TPR_W      = 7,
  parameter int TPR_RESET  = 1,
  parameter int LOW_UNITS  = 6,
  parameter int HIGH_UNITS = 4,
  parameter int DRIVE_UNIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             hold,
  input  logic             scl_in,
  input  logic             prd_wr,
  input  logic [TPR_W:0]   prd_wdata,
  output logic             scl_out,
  output logic             drive_tick,
  output logic             sample_tick,
  output logic             period_tick
);
  localparam int SAMPLE_UNIT = LOW_UNITS + HIGH_UNITS / 2;

  logic [TPR_W-1:0] tpr_shadow;
  logic             advance;
  logic             period_end;
  logic             unit_start;
  logic             unit_end;
  logic             reload;

  // the value in use is refreshed while idle or on the wrapping edge
  assign reload = !run_en || (advance && period_end);

  scl_period_reg #(.TPR_W(TPR_W), .TPR_RESET(TPR_RESET)) u_preg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prd_wr),
    .wr_data (prd_wdata),
    .tpr_q   (tpr_shadow)
  );

  scl_prescaler #(.TPR_W(TPR_W), .TPR_RESET(TPR_RESET)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .advance    (advance),
    .reload     (reload),
    .tpr_next   (tpr_shadow),
    .unit_start (unit_start),
    .unit_end   (unit_end)
  );

  scl_phase_seq #(
    .LOW_UNITS   (LOW_UNITS),
    .HIGH_UNITS  (HIGH_UNITS),
    .DRIVE_UNIT  (DRIVE_UNIT),
    .SAMPLE_UNIT (SAMPLE_UNIT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .hold        (hold),
    .scl_in      (scl_in),
    .unit_start  (unit_start),
    .unit_end    (unit_end),
    .advance     (advance),
    .period_end  (period_end),
    .scl_out     (scl_out),
    .drive_tick  (drive_tick),
    .sample_tick (sample_tick),
    .period_tick (period_tick)
  );
endmodule

// File: rtl/scl_timebase_chk.sv
module scl_timebase_chk #(
  parameter int TPR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             hold,
  input logic             scl_in,
  input logic             prd_wr,
  input logic [TPR_W:0]   prd_wdata,
  input logic             scl_out,
  input logic             drive_tick,
  input logic             sample_tick,
  input logic             period_tick,
  input logic [TPR_W-1:0] tpr_shadow
);
  assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({period_tick, drive_tick, sample_tick}));

  assert_period_opens_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> (!run_en || !scl_out));

  assert_drive_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_tick |-> !scl_out);

  assert_sample_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (scl_out && scl_in));

  assert_stretch_keeps_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && scl_out && !scl_in) |=> (!run_en || scl_out));

  assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && hold) |=> (!run_en || $stable(scl_out)));

  assert_restart_ticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!run_en || hold || period_tick));

  assert_guard_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_wr && prd_wdata[TPR_W]) |=> $stable(tpr_shadow));

  assert_never_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_wr && !prd_wdata[TPR_W]) |=> (tpr_shadow != '0));
endmodule

bind scl_timebase scl_timebase_chk #(.TPR_W(TPR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .hold        (hold),
  .scl_in      (scl_in),
  .prd_wr      (prd_wr),
  .prd_wdata   (prd_wdata),
  .scl_out     (scl_out),
  .drive_tick  (drive_tick),
  .sample_tick (sample_tick),
  .period_tick (period_tick),
  .tpr_shadow  (tpr_shadow)
);

// File: tb/sim_scl_timebase.sv
`timescale 1ns/1ps
module sim_scl_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       hold = 1'b0;
  logic       stretch = 1'b0;
  logic       prd_wr = 1'b0;
  logic [7:0] prd_wdata = 8'h00;
  logic       scl_in;
  logic       scl_out, drive_tick, sample_tick, period_tick;

  int errors = 0;
  int checks = 0;
  int cyc_n = 0;
  int last_tick = 0;
  int gap = 0;

  // reference model state
  int m_pc = 0, m_uc = 0, m_sh = 1, m_act = 1;

  always #2 clk = ~clk;  // 250 MHz

  // the line reads back low while a target stretches it
  assign scl_in = scl_out && !stretch;

  scl_timebase u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .hold(hold), .scl_in(scl_in),
    .prd_wr(prd_wr), .prd_wdata(prd_wdata), .scl_out(scl_out),
    .drive_tick(drive_tick), .sample_tick(sample_tick), .period_tick(period_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, then model step for the coming edge
  always @(negedge clk) begin
    bit m_high, m_sclin, m_stall, m_adv;
    int e_scl, e_tick, e_drv, e_smp, lim, n_sh;
    m_high  = (m_uc >= 6);
    e_scl   = (!run_en || m_high) ? 1 : 0;
    m_sclin = e_scl[0] && !stretch;
    m_stall = hold || (m_high && !m_sclin);
    m_adv   = run_en && !m_stall;
    e_tick  = (m_adv && m_pc == 0 && m_uc == 0) ? 1 : 0;
    e_drv   = (m_adv && m_pc == 0 && m_uc == 3) ? 1 : 0;
    e_smp   = (m_adv && m_pc == 0 && m_uc == 8) ? 1 : 0;
    chk(scl_out == e_scl[0], "R2 scl level", scl_out, e_scl);
    chk(period_tick == e_tick[0], "R8 period_tick", period_tick, e_tick);
    chk(drive_tick == e_drv[0], "R6 drive_tick", drive_tick, e_drv);
    chk(sample_tick == e_smp[0], "R7 sample_tick", sample_tick, e_smp);
    if (!rst_n) begin
      m_pc = 0; m_uc = 0; m_sh = 1; m_act = 1;
    end else begin
      lim  = 2 * m_act + 1;
      n_sh = m_sh;
      if (prd_wr && !prd_wdata[7]) n_sh = (prd_wdata[6:0] == 0) ? 1 : int'(prd_wdata[6:0]);
      if (!run_en) begin
        m_pc = 0; m_uc = 0; m_act = m_sh;
      end else if (m_adv) begin
        if (m_pc == lim) begin
          m_pc = 0;
          if (m_uc == 9) begin m_uc = 0; m_act = m_sh; end
          else m_uc = m_uc + 1;
        end else m_pc = m_pc + 1;
      end
      m_sh = n_sh;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #0.5;
    cyc_n++;
  endtask

  task automatic wait_tick();
    do cyc(); while (!period_tick);
    gap = cyc_n - last_tick;
    last_tick = cyc_n;
  endtask

  task automatic write_prd(input logic [7:0] v);
    prd_wr = 1'b1; prd_wdata = v;
    cyc();
    prd_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset with generator disabled
    repeat (3) cyc();
    chk(scl_out == 1'b1, "R1 scl in reset", scl_out, 1);
    chk({drive_tick, sample_tick, period_tick} == 3'b000, "R1 strobes in reset",
        {drive_tick, sample_tick, period_tick}, 0);
    rst_n = 1'b1;
    cyc();
    run_en = 1'b1;

    // R2: default T=1 gives 40 clocks
    wait_tick(); wait_tick();
    chk(gap == 40, "R2 default period", gap, 40);
    wait_tick();
    chk(gap == 40, "R2 default period again", gap, 40);

    // R3: guarded writes are dropped
    write_prd(8'h83);
    write_prd(8'hFF);
    wait_tick(); wait_tick();
    chk(gap == 40, "R3 guarded write ignored", gap, 40);

    // R5: mid-period write applies to the next period only
    repeat (10) cyc();
    write_prd(8'h05);
    wait_tick();
    chk(gap == 40, "R5 current period unchanged", gap, 40);
    wait_tick();
    chk(gap == 120, "R4 R5 new period length", gap, 120);

    // R4: zero field is stored as one
    write_prd(8'h00);
    wait_tick();
    chk(gap == 120, "R4 period before clamp", gap, 120);
    wait_tick();
    chk(gap == 40, "R4 zero clamped to one", gap, 40);

    // R5: write sampled on the wrapping edge
    wait_tick();
    repeat (39) cyc();
    write_prd(8'h02);
    wait_tick();
    chk(gap == 80, "R5 wrap-edge write keeps old period", gap, 80);
    wait_tick();
    chk(gap == 60, "R5 wrap-edge write then applies", gap, 60);

    // R10: hold freezes the generator
    repeat (5) cyc();
    hold = 1'b1;
    repeat (15) cyc();
    chk(scl_out == 1'b0, "R10 scl frozen low", scl_out, 0);
    hold = 1'b0;
    wait_tick();
    chk(gap == 75, "R10 hold lengthens period", gap, 75);

    // R9: target stretches the high phase
    do cyc(); while (!scl_out);
    stretch = 1'b1;
    repeat (7) cyc();
    chk(scl_out == 1'b1, "R9 released during stretch", scl_out, 1);
    stretch = 1'b0;
    wait_tick();
    chk(gap == 67, "R9 stretch lengthens period", gap, 67);

    // R11: disable mid-period, then restart
    repeat (10) cyc();
    run_en = 1'b0;
    #0.5;
    chk(scl_out == 1'b1, "R11 released when disabled", scl_out, 1);
    repeat (5) cyc();
    run_en = 1'b1;
    #0.5;
    chk(period_tick == 1'b1, "R11 restart tick", period_tick, 1);
    last_tick = cyc_n;
    wait_tick();
    chk(gap == 60, "R11 full period after restart", gap, 60);

    repeat (5) cyc();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule